// File: doc/BRIEF.md
# Sleep and Idle Power Controller

This block sequences the power modes of a small microcontroller core. It has three modes: run, idle and sleep. The CPU asks for a low-power mode with a single request strobe whose two-bit operand names the target mode. In idle, only the CPU clock is gated off and the peripherals keep running. In sleep, the CPU clock, the peripheral clock and the main oscillator enable are all removed. The clock-fail monitor is held off, and the watchdog gets a clear strobe as sleep begins.

Three kinds of event wake the block. The first is an interrupt request whose individual enable bit is set. The second is a watchdog time-out. The third is a synchronous device reset request. The block latches the cause of each wake as a two-bit code. On a wake from sleep, the block first turns the oscillator back on. It uses the clock source that was selected when sleep began. The CPU and peripheral clocks come back only after a configurable number of oscillator start-up cycles. A wake from idle gives the CPU its clock back on the next cycle.

The low-power RC clock stays on through sleep while the watchdog is enabled. Other requests for that clock are dropped while the oscillator is down.

Top module: `power_mode_unit`

## Requirements
- R1: `curMode` reports 2'b00 in run, 2'b01 in idle and 2'b10 in sleep, including the oscillator start-up wait. A request with `saveMode`=2'b01 enters idle, and one with 2'b10 enters sleep. The new mode shows one clock after the request is sampled.
- R2: A request with operand 2'b00 or 2'b11 is ignored. The block stays in run, the clocks stay enabled and `wakeCause` keeps its value.
- R3: In idle, `cpuClkEn`=0, `periClkEn`=1, and `oscEn` keeps the selected source on.
- R4: In sleep, `cpuClkEn`, `periClkEn` and every bit of `oscEn` are 0, and `clkMonEn` is 0 whatever `clkMonCfg` is.
- R5: A wake event is one of three things. It is an interrupt with both `irqPend[i]` and `irqEn[i]` set, or `wdtTimeout`, or `devResetReq`. An interrupt that is pending with its enable bit clear has no effect.
- R6: On each wake, `wakeCause` latches 2'b01 for an interrupt, 2'b10 for the watchdog and 2'b11 for a reset. A reset outranks the watchdog, and the watchdog outranks an interrupt, when they arrive in the same cycle. The code holds until the next wake.
- R7: A wake event in idle returns the block to run one clock later, with `cpuClkEn`=1.
- R8: On a wake from sleep, `oscEn` turns on, one-hot, the source index that `oscSel` held when sleep was entered, even if `oscSel` has changed since. `cpuClkEn` and `periClkEn` stay 0 for OSC_WAIT clocks after the wake is sampled, and then return to 1.
- R9: `wdtClr` is a one-clock pulse in the first sleep cycle, and only when `wdtEnable` is 1. It is never asserted for idle entry.
- R10: `lowRcEn` is 1 whenever `wdtEnable` is 1, in every mode. `lowRcReq` turns it on only outside sleep and the start-up wait.
- R11: If a wake event is present in the same cycle as a valid request, the block stays in run with no clock gated, and `wakeCause` latches the code of that event.
- R12: After `rstN` is released, the block is in run with all clocks enabled, `wakeCause`=2'b00 and `wdtClr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| saveReq | input | 1 | Power-save request strobe from the CPU |
| saveMode | input | 2 | Request operand: 01 idle, 10 sleep |
| irqPend | input | NUM_IRQ | Pending interrupt requests |
| irqEn | input | NUM_IRQ | Per-source interrupt enable mask |
| wdtTimeout | input | 1 | Watchdog time-out event |
| wdtEnable | input | 1 | Watchdog is enabled |
| devResetReq | input | 1 | Synchronous device reset request |
| oscSel | input | SRC_W | Currently selected system clock source |
| clkMonCfg | input | 1 | Clock-fail monitor configured on |
| lowRcReq | input | 1 | Other users request the low-power RC clock |
| cpuClkEn | output | 1 | CPU clock enable |
| periClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | NUM_SRC | One-hot oscillator enables |
| wdtClr | output | 1 | Watchdog clear strobe |
| lowRcEn | output | 1 | Low-power RC clock enable |
| clkMonEn | output | 1 | Clock-fail monitor enable |
| curMode | output | 2 | Current power mode code |
| wakeCause | output | 2 | Latched wake cause code |

## Verification
Mode, clock enables and `wdtClr` come from registers, so they change one clock after the request or wake event is sampled. The exception is the oscillator start-up wait, where `cpuClkEn` returns OSC_WAIT clocks after the wake sample. `wakeCause` also updates one clock after the event. `lowRcEn` and `clkMonEn` respond within the same cycle to `wdtEnable`, `lowRcReq` and `clkMonCfg`, and they depend on the current mode. The bench drives inputs on the falling edge, advances a cycle model of the requirements at the rising edge, and compares every output on the following falling edge. This means each result is checked in exactly the cycle it becomes due.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_IDLE  = 2'b01,
    PM_SLEEP = 2'b10,
    PM_WAKE  = 2'b11
  } pmState_t;

  localparam logic [1:0] OP_IDLE  = 2'b01;
  localparam logic [1:0] OP_SLEEP = 2'b10;

  localparam logic [1:0] CAUSE_NONE = 2'b00;
  localparam logic [1:0] CAUSE_IRQ  = 2'b01;
  localparam logic [1:0] CAUSE_WDT  = 2'b10;
  localparam logic [1:0] CAUSE_RST  = 2'b11;

  typedef struct packed {
    logic loadCause;
    logic loadWait;
    logic decWait;
    logic trackSrc;
    logic armWdtClr;
  } pmStrobe_t;

endpackage

// File: rtl/pmu_control.sv
module pmu_control
  import pmu_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      saveReq,
  input  logic [1:0] saveMode,
  input  logic      wakeAny,
  input  logic      waitDone,
  input  logic      wdtEnable,
  output pmState_t  stateQ,
  output pmStrobe_t strobe,
  output logic      cpuClkEn,
  output logic      periClkEn,
  output logic      oscRun,
  output logic      lowPower
);

  pmState_t stateD;
  logic     validOp;

  assign validOp = saveReq && (saveMode == OP_IDLE || saveMode == OP_SLEEP);

  always_comb begin
    stateD           = stateQ;
    strobe           = '0;
    strobe.trackSrc  = (stateQ == PM_RUN) || (stateQ == PM_IDLE);
    unique case (stateQ)
      PM_RUN: begin
        if (validOp) begin
          if (wakeAny) begin
            strobe.loadCause = 1'b1;
          end else if (saveMode == OP_IDLE) begin
            stateD = PM_IDLE;
          end else begin
            stateD           = PM_SLEEP;
            strobe.armWdtClr = wdtEnable;
          end
        end
      end
      PM_IDLE: begin
        if (wakeAny) begin
          stateD           = PM_RUN;
          strobe.loadCause = 1'b1;
        end
      end
      PM_SLEEP: begin
        if (wakeAny) begin
          stateD           = PM_WAKE;
          strobe.loadCause = 1'b1;
          strobe.loadWait  = 1'b1;
        end
      end
      PM_WAKE: begin
        strobe.decWait = 1'b1;
        if (waitDone) begin
          stateD = PM_RUN;
        end
      end
      default: stateD = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= PM_RUN;
    end else begin
      stateQ <= stateD;
    end
  end

  assign cpuClkEn  = (stateQ == PM_RUN);
  assign periClkEn = (stateQ == PM_RUN) || (stateQ == PM_IDLE);
  assign oscRun    = (stateQ != PM_SLEEP);
  assign lowPower  = (stateQ == PM_SLEEP) || (stateQ == PM_WAKE);

  AST_IDLE_WAKE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PM_IDLE && wakeAny) |=> (stateQ == PM_RUN && cpuClkEn)); // R7

  AST_BAD_OP_STAYS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PM_RUN && saveReq && saveMode != OP_IDLE && saveMode != OP_SLEEP)
      |=> (stateQ == PM_RUN)); // R2

  AST_ABORT_STAYS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PM_RUN && saveReq && wakeAny) |=> (stateQ == PM_RUN && cpuClkEn)); // R11

  AST_SLEEP_EXIT_PATH: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PM_SLEEP) |=> (stateQ == PM_SLEEP || stateQ == PM_WAKE)); // R8

  AST_WAKE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PM_WAKE && waitDone) |=> (stateQ == PM_RUN)); // R8

endmodule

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int NUM_SRC  = 4,
  parameter int OSC_WAIT = 5,
  localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CNT_W   = (OSC_WAIT > 1) ? $clog2(OSC_WAIT) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  pmStrobe_t          strobe,
  input  logic [NUM_IRQ-1:0] irqPend,
  input  logic [NUM_IRQ-1:0] irqEn,
  input  logic               wdtTimeout,
  input  logic               devResetReq,
  input  logic [SRC_W-1:0]   oscSel,
  input  logic               oscRun,
  output logic               wakeAny,
  output logic               waitDone,
  output logic [1:0]         wakeCause,
  output logic [NUM_SRC-1:0] oscEn,
  output logic               wdtClr
);

  localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(OSC_WAIT - 1);

  logic [NUM_IRQ-1:0] irqHitVec;
  logic               irqHit;
  logic [1:0]         wakeCode;
  logic [CNT_W-1:0]   waitCnt;
  logic [SRC_W-1:0]   activeSrc;

  // Per-source qualification of pending requests by their enables.
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irqQual
    assign irqHitVec[i] = irqPend[i] & irqEn[i];
  end
  assign irqHit  = |irqHitVec;
  assign wakeAny = devResetReq | wdtTimeout | irqHit;

  // Cause priority: reset, then watchdog, then interrupt.
  always_comb begin
    if (devResetReq)     wakeCode = CAUSE_RST;
    else if (wdtTimeout) wakeCode = CAUSE_WDT;
    else if (irqHit)     wakeCode = CAUSE_IRQ;
    else                 wakeCode = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeCause <= CAUSE_NONE;
    end else if (strobe.loadCause) begin
      wakeCause <= wakeCode;
    end
  end

  // Oscillator start-up counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobe.loadWait) begin
      waitCnt <= WAIT_LOAD;
    end else if (strobe.decWait && waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end
  assign waitDone = (waitCnt == '0);

  // Source snapshot: follows the selection while awake, frozen otherwise.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeSrc <= '0;
    end else if (strobe.trackSrc) begin
      activeSrc <= oscSel;
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_oscDecode
    assign oscEn[s] = oscRun && (activeSrc == SRC_W'(s));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdtClr <= 1'b0;
    end else begin
      wdtClr <= strobe.armWdtClr;
    end
  end

  AST_WDT_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wdtClr |=> !wdtClr); // R9

  AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.trackSrc |=> $stable(activeSrc)); // R8

  AST_WAIT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= WAIT_LOAD); // R8

  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCause |=> (wakeCause != CAUSE_NONE)); // R6

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadCause && devResetReq) |=> (wakeCause == CAUSE_RST)); // R6

endmodule

// File: rtl/power_mode_unit.sv
module power_mode_unit
  import pmu_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int NUM_SRC  = 4,
  parameter int OSC_WAIT = 5,
  localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               saveReq,
  input  logic [1:0]         saveMode,
  input  logic [NUM_IRQ-1:0] irqPend,
  input  logic [NUM_IRQ-1:0] irqEn,
  input  logic               wdtTimeout,
  input  logic               wdtEnable,
  input  logic               devResetReq,
  input  logic [SRC_W-1:0]   oscSel,
  input  logic               clkMonCfg,
  input  logic               lowRcReq,
  output logic               cpuClkEn,
  output logic               periClkEn,
  output logic [NUM_SRC-1:0] oscEn,
  output logic               wdtClr,
  output logic               lowRcEn,
  output logic               clkMonEn,
  output logic [1:0]         curMode,
  output logic [1:0]         wakeCause
);

  pmState_t  stateQ;
  pmStrobe_t strobe;
  logic      wakeAny;
  logic      waitDone;
  logic      oscRun;
  logic      lowPower;

  pmu_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .saveReq   (saveReq),
    .saveMode  (saveMode),
    .wakeAny   (wakeAny),
    .waitDone  (waitDone),
    .wdtEnable (wdtEnable),
    .stateQ    (stateQ),
    .strobe    (strobe),
    .cpuClkEn  (cpuClkEn),
    .periClkEn (periClkEn),
    .oscRun    (oscRun),
    .lowPower  (lowPower)
  );

  pmu_datapath #(
    .NUM_IRQ  (NUM_IRQ),
    .NUM_SRC  (NUM_SRC),
    .OSC_WAIT (OSC_WAIT)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .irqPend     (irqPend),
    .irqEn       (irqEn),
    .wdtTimeout  (wdtTimeout),
    .devResetReq (devResetReq),
    .oscSel      (oscSel),
    .oscRun      (oscRun),
    .wakeAny     (wakeAny),
    .waitDone    (waitDone),
    .wakeCause   (wakeCause),
    .oscEn       (oscEn),
    .wdtClr      (wdtClr)
  );

  assign curMode  = (stateQ == PM_WAKE) ? 2'(PM_SLEEP) : 2'(stateQ);
  assign clkMonEn = clkMonCfg & ~lowPower;
  assign lowRcEn  = wdtEnable | (lowRcReq & ~lowPower);

  AST_WDT_CLR_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    wdtClr |-> (curMode == 2'b10 && $past(curMode) == 2'b00)); // R9

  AST_SLEEP_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 2'b10) |-> (!cpuClkEn && !periClkEn && !clkMonEn)); // R4

  AST_LOWRC_WITH_WDT: assert property (@(posedge clk) disable iff (!rstN)
    wdtEnable |-> lowRcEn); // R10

endmodule

// File: tb/test_power_mode_unit.sv
module test_power_mode_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_IRQ    = 8;
  localparam int NUM_SRC    = 4;
  localparam int OSC_WAIT   = 5;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               saveReq = 1'b0;
  logic [1:0]         saveMode = 2'b00;
  logic [NUM_IRQ-1:0] irqPend = '0;
  logic [NUM_IRQ-1:0] irqEn = '0;
  logic               wdtTimeout = 1'b0;
  logic               wdtEnable = 1'b0;
  logic               devResetReq = 1'b0;
  logic [1:0]         oscSel = 2'd0;
  logic               clkMonCfg = 1'b1;
  logic               lowRcReq = 1'b0;
  logic               cpuClkEn;
  logic               periClkEn;
  logic [NUM_SRC-1:0] oscEn;
  logic               wdtClr;
  logic               lowRcEn;
  logic               clkMonEn;
  logic [1:0]         curMode;
  logic [1:0]         wakeCause;

  int    checks = 0;
  int    failures = 0;
  string tagNow = "reset";

  // Reference model state: 0 run, 1 idle, 2 sleep, 3 start-up wait.
  int mState = 0;
  int mCnt = 0;
  int mCause = 0;
  int mSrc = 0;
  int mWdtClr = 0;

  power_mode_unit #(
    .NUM_IRQ(NUM_IRQ), .NUM_SRC(NUM_SRC), .OSC_WAIT(OSC_WAIT)
  ) i_power_mode_unit (
    .clk(clk), .rstN(rstN), .saveReq(saveReq), .saveMode(saveMode),
    .irqPend(irqPend), .irqEn(irqEn), .wdtTimeout(wdtTimeout),
    .wdtEnable(wdtEnable), .devResetReq(devResetReq), .oscSel(oscSel),
    .clkMonCfg(clkMonCfg), .lowRcReq(lowRcReq), .cpuClkEn(cpuClkEn),
    .periClkEn(periClkEn), .oscEn(oscEn), .wdtClr(wdtClr),
    .lowRcEn(lowRcEn), .clkMonEn(clkMonEn), .curMode(curMode),
    .wakeCause(wakeCause)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic checkEq(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL [%s] %s actual=%0d expected=%0d", tagNow, what, act, exp);
    end
  endtask

  function automatic int wakeCodeNow();
    if (devResetReq) return 3;
    if (wdtTimeout) return 2;
    if ((irqPend & irqEn) != '0) return 1;
    return 0;
  endfunction

  function automatic int expModeCode();
    return (mState == 3) ? 2 : mState;
  endfunction

  // Advance the model across one rising edge using the current inputs.
  task automatic modelNext();
    int code;
    int nState;
    int nCnt;
    int nCause;
    int nSrc;
    int nClr;
    code   = wakeCodeNow();
    nState = mState;
    nCnt   = mCnt;
    nCause = mCause;
    nSrc   = (mState == 0 || mState == 1) ? int'(oscSel) : mSrc;
    nClr   = 0;
    case (mState)
      0: if (saveReq && (saveMode == 2'b01 || saveMode == 2'b10)) begin
           if (code != 0) nCause = code;
           else begin
             nState = int'(saveMode);
             if (saveMode == 2'b10 && wdtEnable) nClr = 1;
           end
         end
      1: if (code != 0) begin nState = 0; nCause = code; end
      2: if (code != 0) begin nState = 3; nCause = code; nCnt = OSC_WAIT - 1; end
      default: begin
        if (mCnt == 0) nState = 0;
        else nCnt = mCnt - 1;
      end
    endcase
    mState = nState; mCnt = nCnt; mCause = nCause; mSrc = nSrc; mWdtClr = nClr;
  endtask

  task automatic compareAll();
    int lowP;
    int expOsc;
    lowP   = (mState >= 2) ? 1 : 0;
    expOsc = (mState == 2) ? 0 : (1 << mSrc);
    checkEq("R1 curMode", int'(curMode), expModeCode());
    checkEq("R3 R4 R8 cpuClkEn", int'(cpuClkEn), (mState == 0) ? 1 : 0);
    checkEq("R3 R4 R8 periClkEn", int'(periClkEn), (mState <= 1) ? 1 : 0);
    checkEq("R4 R8 oscEn", int'(oscEn), expOsc);
    checkEq("R6 wakeCause", int'(wakeCause), mCause);
    checkEq("R9 wdtClr", int'(wdtClr), mWdtClr);
    checkEq("R4 clkMonEn", int'(clkMonEn), (clkMonCfg && lowP == 0) ? 1 : 0);
    checkEq("R10 lowRcEn", int'(lowRcEn), (wdtEnable || (lowRcReq && lowP == 0)) ? 1 : 0);
  endtask

  task automatic step();
    modelNext();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic quiet();
    saveReq = 1'b0; saveMode = 2'b00; irqPend = '0; irqEn = '0;
    wdtTimeout = 1'b0; devResetReq = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R12: state right after reset release
    tagNow = "R12 reset";
    compareAll();
    checkEq("R12 curMode after reset", int'(curMode), 0);
    checkEq("R12 wakeCause after reset", int'(wakeCause), 0);
    checkEq("R12 cpuClkEn after reset", int'(cpuClkEn), 1);
    step();

    // R1 R3: idle entry
    tagNow = "R1 R3 idle";
    saveReq = 1'b1; saveMode = 2'b01; lowRcReq = 1'b1;
    step();
    checkEq("R1 idle mode code", int'(curMode), 1);
    checkEq("R3 cpu gated in idle", int'(cpuClkEn), 0);
    checkEq("R3 peripherals run in idle", int'(periClkEn), 1);
    checkEq("R9 no clear for idle", int'(wdtClr), 0);
    quiet();
    step(); step();
    // R5: masked interrupt has no effect
    tagNow = "R5 masked";
    irqPend = 8'h10; irqEn = 8'hEF;
    step();
    checkEq("R5 masked irq keeps idle", int'(curMode), 1);
    // R7: enabled interrupt wakes idle in one clock
    tagNow = "R7 idle wake";
    irqEn = 8'h10;
    step();
    checkEq("R7 run after idle wake", int'(cpuClkEn), 1);
    checkEq("R6 irq cause", int'(wakeCause), 1);
    quiet();

    // R2: invalid operands
    tagNow = "R2 bad op";
    saveReq = 1'b1; saveMode = 2'b11;
    step();
    checkEq("R2 op 11 ignored", int'(curMode), 0);
    saveMode = 2'b00;
    step();
    checkEq("R2 op 00 ignored", int'(cpuClkEn), 1);
    checkEq("R2 cause kept", int'(wakeCause), 1);
    quiet();

    // R4 R8 R9 R10: sleep with watchdog enabled
    tagNow = "R4 R9 sleep";
    oscSel = 2'd2; wdtEnable = 1'b1;
    step();
    saveReq = 1'b1; saveMode = 2'b10;
    step();
    checkEq("R9 clear pulse on sleep entry", int'(wdtClr), 1);
    checkEq("R4 oscillator off", int'(oscEn), 0);
    checkEq("R4 monitor off", int'(clkMonEn), 0);
    checkEq("R10 low RC kept by watchdog", int'(lowRcEn), 1);
    quiet(); oscSel = 2'd1;
    step();
    checkEq("R9 clear is one cycle", int'(wdtClr), 0);
    tagNow = "R6 R8 sleep wake";
    wdtTimeout = 1'b1; irqPend = 8'h01; irqEn = 8'h01;
    step();
    checkEq("R6 watchdog beats irq", int'(wakeCause), 2);
    checkEq("R8 saved source restored", int'(oscEn), 4);
    quiet();
    for (int k = 0; k < OSC_WAIT - 1; k++) begin
      step();
      checkEq("R8 cpu held during start-up", int'(cpuClkEn), 0);
    end
    step();
    checkEq("R8 cpu back after start-up", int'(cpuClkEn), 1);

    // R9 R10 R6: sleep with watchdog disabled, reset wakes
    tagNow = "R10 sleep nowdt";
    wdtEnable = 1'b0; lowRcReq = 1'b1;
    saveReq = 1'b1; saveMode = 2'b10;
    step();
    checkEq("R9 no clear without watchdog", int'(wdtClr), 0);
    checkEq("R10 low RC request dropped in sleep", int'(lowRcEn), 0);
    quiet();
    devResetReq = 1'b1; wdtTimeout = 1'b1; irqPend = 8'h80; irqEn = 8'h80;
    step();
    checkEq("R6 reset beats all", int'(wakeCause), 3);
    quiet();
    repeat (OSC_WAIT) step();

    // R11: abort on pending wake
    tagNow = "R11 abort";
    irqPend = 8'h04; irqEn = 8'h04; saveReq = 1'b1; saveMode = 2'b10; wdtEnable = 1'b1;
    step();
    checkEq("R11 stays run", int'(curMode), 0);
    checkEq("R11 no clear", int'(wdtClr), 0);
    checkEq("R11 cause latched", int'(wakeCause), 1);
    quiet();
    step();

    // Random phase
    tagNow = "random R1 R5 R6";
    for (int n = 0; n < 4000; n++) begin
      saveReq     = ($urandom % 6) == 0;
      saveMode    = 2'($urandom % 4);
      irqPend     = (($urandom % 10) == 0) ? 8'($urandom) : '0;
      irqEn       = 8'($urandom);
      wdtTimeout  = ($urandom % 30) == 0;
      devResetReq = ($urandom % 60) == 0;
      if (($urandom % 8) == 0) oscSel = 2'($urandom % 4);
      if (($urandom % 40) == 0) wdtEnable = ~wdtEnable;
      lowRcReq    = ($urandom % 2) == 0;
      clkMonCfg   = ($urandom % 4) != 0;
      step();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule